// File: doc/BRIEF.md
# Two-Level Fixed-Order Interrupt Vector Controller

This block gathers five interrupt requests, decides which one the processor should service next, and supplies the vector address to load into the program counter. Four of the sources raise edge events: external line 0, timer 0 overflow, external line 1 and timer 1 overflow. The block latches each event as a pending flag. The fifth source is the serial port. Its request is the OR of its receive and transmit flags, and the block follows those flags as levels.

Each source has an enable bit and a priority bit that selects the high or the low level. A global enable gates every source. Within a level, the sources are ranked in a fixed order. The block keeps one in-service bit per level. A high-level request can interrupt a low-level handler, and nothing can interrupt a high-level handler. A return-from-interrupt pulse ends the innermost active service.

An acceptance appears as a one-cycle `take` pulse with the vector and the source number. The processor is expected to branch to that vector.

Top module: `intc_vec`

## Requirements
- R1: After reset, `take`, `in_svc_hi`, `in_svc_lo`, `vec` and `src_id` are all zero, and no edge flag is pending.
- R2: While `glb_en` is low, no request is accepted and pending flags are kept. Once `glb_en` rises, the waiting request is accepted.
- R3: A source whose bit in `src_en` is clear is not accepted, and its flag stays pending. After the bit is set, the source is accepted.
- R4: Among pending, enabled requests of the same level, the winner is chosen in a fixed order. The order is external 0, then timer 0, then external 1, then timer 1, then serial. `src_id` reports the winner as 0, 1, 2, 3 and 4 respectively.
- R5: An acceptance gives a one-cycle `take` pulse. During the pulse, `vec` = 0x0003 + 8·`src_id`, so the vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023. For an edge source, `take` rises on the second clock edge after the set pulse is sampled. For the serial level, `take` rises on the first clock edge after the level is seen.
- R6: A request whose bit in `src_hi` is 1 (high level) is accepted while a low-level handler is in service. After that, `in_svc_hi` and `in_svc_lo` are both 1.
- R7: While `in_svc_hi` is 1, no request is accepted. While only `in_svc_lo` is 1, a low-level request waits.
- R8: A `reti` pulse clears `in_svc_hi` if it is set, and otherwise clears `in_svc_lo`. A waiting request can be accepted from the second edge after `reti` is seen.
- R9: Acceptance clears the edge flag of the accepted source. If a set pulse arrives in the same cycle, the set wins. `pend[4]` follows `ser_rx | ser_tx` and is not cleared by acceptance.
- R10: When high-level and low-level requests are pending at the same time, the high-level request wins, whatever their places in the fixed order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| x0_set | input | 1 | External line 0 event pulse |
| t0_set | input | 1 | Timer 0 overflow event pulse |
| x1_set | input | 1 | External line 1 event pulse |
| t1_set | input | 1 | Timer 1 overflow event pulse |
| ser_rx | input | 1 | Serial receive flag (level) |
| ser_tx | input | 1 | Serial transmit flag (level) |
| glb_en | input | 1 | Global enable |
| src_en | input | 5 | Per-source enables, bit i = source i |
| src_hi | input | 5 | Per-source level, 1 = high |
| reti | input | 1 | Return-from-interrupt pulse |
| take | output | 1 | One-cycle acceptance pulse |
| vec | output | PC_W | Vector address of the last accepted source |
| src_id | output | 3 | Number of the last accepted source |
| in_svc_hi | output | 1 | High level in service |
| in_svc_lo | output | 1 | Low level in service |
| pend | output | 5 | Pending requests, bit i = source i |

## Verification
The bench holds all five requests back with the global enable and then releases them together. A design with the wrong tie-break would report a different sequence of source numbers or vectors. The bench then gives the serial source the high level while external 0 waits at the low level. A design that ranked by fixed position alone would take external 0 first, and a design that let a pending request interrupt a high handler would give a second `take` during that handler. In a nested case, the bench checks three things: that a high request interrupts a low handler, that a low request stays pending during the low handler, and that the first `reti` clears only the high bit. A design that cleared both levels would admit the low request one return too early. After acceptance, the bench also checks the pending flags, so that a serial request cleared by mistake, or an edge flag left set, is caught.

// File: rtl/intc_vec.sv
module intc_vec #(
  parameter int PC_W     = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x0_set,
  input  logic            t0_set,
  input  logic            x1_set,
  input  logic            t1_set,
  input  logic            ser_rx,
  input  logic            ser_tx,
  input  logic            glb_en,
  input  logic [4:0]      src_en,
  input  logic [4:0]      src_hi,
  input  logic            reti,
  output logic            take,
  output logic [PC_W-1:0] vec,
  output logic [2:0]      src_id,
  output logic            in_svc_hi,
  output logic            in_svc_lo,
  output logic [4:0]      pend
);
  localparam logic [PC_W-1:0] BASE = PC_W'(VEC_BASE);
  localparam logic [PC_W-1:0] STEP = PC_W'(VEC_STEP);

  logic [3:0] edge_flg;
  logic [3:0] edge_set;
  logic [4:0] elig, elig_hi, elig_lo, pool;
  logic       go_hi, go_lo, go;
  logic [2:0] idx;

  assign edge_set = {t1_set, x1_set, t0_set, x0_set};
  assign pend     = {ser_rx | ser_tx, edge_flg};

  assign elig    = pend & src_en & {5{glb_en}};
  assign elig_hi = elig & src_hi;
  assign elig_lo = elig & ~src_hi;

  assign go_hi = (|elig_hi) & ~in_svc_hi;
  assign go_lo = ~go_hi & (|elig_lo) & ~in_svc_hi & ~in_svc_lo;
  assign go    = go_hi | go_lo;
  assign pool  = go_hi ? elig_hi : elig_lo;

  always_comb begin
    idx = 3'd0;
    for (int i = 4; i >= 0; i--)
      if (pool[i]) idx = 3'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_flg  <= '0;
      take      <= 1'b0;
      vec       <= '0;
      src_id    <= '0;
      in_svc_hi <= 1'b0;
      in_svc_lo <= 1'b0;
    end else begin
      for (int i = 0; i < 4; i++)
        edge_flg[i] <= edge_set[i] | (edge_flg[i] & ~(go && idx == 3'(i)));
      take      <= go;
      if (go) begin
        vec    <= BASE + STEP * PC_W'(idx);
        src_id <= idx;
      end
      in_svc_hi <= (in_svc_hi & ~reti) | go_hi;
      in_svc_lo <= (in_svc_lo & ~(reti & ~in_svc_hi)) | go_lo;
    end
  end
endmodule

module intc_vec_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            glb_en,
  input logic            reti,
  input logic            take,
  input logic [PC_W-1:0] vec,
  input logic [2:0]      src_id,
  input logic            in_svc_hi,
  input logic            in_svc_lo
);
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !take);

  p_vec_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (src_id <= 3'd4 && vec == PC_W'(3) + PC_W'(8) * PC_W'(src_id)));

  p_hi_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc_hi |=> !take);

  p_lo_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_lo && !in_svc_hi) |=> (!take || in_svc_hi));

  p_reti_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && in_svc_hi) |=> (!in_svc_hi && in_svc_lo == $past(in_svc_lo)));

  p_take_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> (in_svc_hi || in_svc_lo));
endmodule

bind intc_vec intc_vec_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .reti(reti), .take(take),
  .vec(vec), .src_id(src_id), .in_svc_hi(in_svc_hi), .in_svc_lo(in_svc_lo)
);

// File: tb/tb_intc_vec.sv
module tb_intc_vec;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x0_set = 0, t0_set = 0, x1_set = 0, t1_set = 0;
  logic ser_rx = 0, ser_tx = 0, glb_en = 0, reti = 0;
  logic [4:0] src_en = '0, src_hi = '0;
  logic take, in_svc_hi, in_svc_lo;
  logic [15:0] vec;
  logic [2:0] src_id;
  logic [4:0] pend;

  int n_chk = 0, n_bad = 0, cyc = 0;

  intc_vec dut (
    .clk(clk), .rst_n(rst_n), .x0_set(x0_set), .t0_set(t0_set),
    .x1_set(x1_set), .t1_set(t1_set), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .glb_en(glb_en), .src_en(src_en), .src_hi(src_hi), .reti(reti),
    .take(take), .vec(vec), .src_id(src_id), .in_svc_hi(in_svc_hi),
    .in_svc_lo(in_svc_lo), .pend(pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 5000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_take(input string tag, input int id);
    chk({tag, " take"}, int'(take), 1);
    chk({tag, " src_id"}, int'(src_id), id);
    chk({tag, " vec"}, int'(vec), 3 + 8 * id);
  endtask

  task automatic do_reti();
    reti = 1; tick(); reti = 0;
  endtask

  task automatic t_reset();
    chk("R1 take", int'(take), 0);
    chk("R1 svc", int'({in_svc_hi, in_svc_lo}), 0);
    chk("R1 pend", int'(pend), 0);
    chk("R1 vec", int'(vec), 0);
    chk("R1 src_id", int'(src_id), 0);
  endtask

  task automatic t_gate();
    src_en = 5'b11111; src_hi = '0; glb_en = 0;
    x0_set = 1; tick(); x0_set = 0;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R2 no take while gated", int'(take), 0);
    end
    chk("R2 flag kept", int'(pend[0]), 1);
    glb_en = 1; tick();
    expect_take("R2 R5 release", 0);
    chk("R9 edge flag cleared", int'(pend[0]), 0);
    tick(); chk("R5 one-cycle pulse", int'(take), 0);
    do_reti(); tick();
    chk("R8 lo cleared", int'(in_svc_lo), 0);
  endtask

  task automatic t_enable();
    src_en = 5'b11101;
    t0_set = 1; tick(); t0_set = 0;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R3 masked no take", int'(take), 0);
    end
    chk("R3 flag kept", int'(pend[1]), 1);
    src_en = 5'b11111; tick();
    expect_take("R3 unmasked", 1);
    do_reti(); tick();
  endtask

  task automatic t_order();
    glb_en = 0; src_en = 5'b11111; src_hi = '0;
    x0_set = 1; t0_set = 1; x1_set = 1; t1_set = 1; ser_rx = 1;
    tick();
    x0_set = 0; t0_set = 0; x1_set = 0; t1_set = 0;
    glb_en = 1; tick();
    expect_take("R4 first", 0);
    for (int k = 1; k < 5; k++) begin
      do_reti();
      chk("R8 no take in reti edge", int'(take), 0);
      tick();
      expect_take("R4 next in order", k);
    end
    chk("R9 serial not cleared", int'(pend[4]), 1);
    ser_rx = 0;
    do_reti(); tick();
  endtask

  task automatic t_levels();
    glb_en = 0; src_hi = 5'b10000;
    x0_set = 1; tick(); x0_set = 0;
    ser_tx = 1;
    glb_en = 1; tick();
    expect_take("R10 high wins", 4);
    chk("R6 hi svc", int'(in_svc_hi), 1);
    for (int i = 0; i < 2; i++) begin
      tick(); chk("R7 hi handler blocks", int'(take), 0);
    end
    ser_tx = 0;
    do_reti(); tick();
    expect_take("R8 low after hi return", 0);
    chk("R8 lo svc", int'({in_svc_hi, in_svc_lo}), 1);
    src_hi = 5'b00100;
    t0_set = 1; tick(); t0_set = 0;
    tick(); chk("R7 low waits", int'(take), 0);
    chk("R7 low pending", int'(pend[1]), 1);
    x1_set = 1; tick(); x1_set = 0;
    tick();
    expect_take("R6 preempt", 2);
    chk("R6 both svc", int'({in_svc_hi, in_svc_lo}), 3);
    do_reti(); tick();
    chk("R8 only hi cleared", int'({in_svc_hi, in_svc_lo}), 1);
    chk("R7 low still waits", int'(take), 0);
    do_reti(); tick();
    expect_take("R8 low after lo return", 1);
    do_reti(); tick();
    chk("R8 all clear", int'({in_svc_hi, in_svc_lo}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 2);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_gate();
    t_enable();
    t_order();
    t_levels();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule